// File: doc/BRIEF.md
# Output Fault Supervisor with Delay Timers

This block watches the fault comparators of a six-channel power switch stage and decides which channels must be forced off. There are three high-side and three low-side switches. Each channel has an overcurrent flag with its own delay timer. A channel whose overcurrent lasts for the selected delay is latched off and raises a sticky short-circuit flag. An active temperature prewarning latches a shorted channel off on the next clock, without waiting for the delay.

Supply undervoltage and overvoltage each run a delay timer and force every channel off when the timer expires. The undervoltage path also sets a sticky power-supply-fail flag. The supply-driven shutdown ends as soon as the comparator clears. A thermal shutdown forces every channel off and holds them off until the temperature comparator has cleared and software has issued a status-reset pulse.

All timers count a single-cycle tick strobe derived from a slow oscillator. One select input chooses between a long and a short delay for every timer, and every delay count is a parameter. Bit i of the disable mask belongs to the channel that drives overcurrent flag bit i.

Top module: `fsv_fault_supervisor`

## Requirements
- R1: While `oc_flag[i]` stays high, channel i trips once its timer has counted the selected number of tick strobes. `off_mask[i]` and `sc_fault` are high from the clock after the edge that samples the last required tick. One tick fewer leaves them low.
- R2: With `long_dly` = 1 the short-circuit, undervoltage and overvoltage timers use their LONG counts. With `long_dly` = 0 they use their SHORT counts.
- R3: When `oc_flag[i]` and `temp_warn` are both high on a clock edge, and no status reset is applied on that edge, `off_mask[i]` and `sc_fault` are high after that edge.
- R4: A `status_clr` pulse clears every short-circuit latch and `sc_fault` on its edge, and it restarts the short-circuit timers. A short that persists trips again only after another full delay.
- R5: A short-circuit trip on one channel leaves the `off_mask` bits of the other channels unchanged.
- R6: When `uv_flag` stays high for the selected undervoltage count, `psf_fault` is set and all `off_mask` bits are high from the clock after the last required tick.
- R7: When `uv_flag` falls, the undervoltage shutdown ends after the next edge. `psf_fault` stays high until a `status_clr` arrives while `uv_flag` is low.
- R8: When `ov_flag` stays high for the selected overvoltage count, all `off_mask` bits go high. When `ov_flag` falls, they are released after the next edge. Overvoltage never sets `psf_fault`.
- R9: When `temp_shdn` is high, `therm_fault` and every `off_mask` bit are high after the next edge. They stay high until a `status_clr` arrives while `temp_shdn` is low.
- R10: If a timer's condition goes low before the timer expires, its count returns to zero. A later fault needs the full delay again.
- R11: After reset, `off_mask`, `sc_fault`, `psf_fault` and `therm_fault` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Single-cycle timebase strobe |
| long_dly | input | 1 | 1 = long delays, 0 = short delays |
| status_clr | input | 1 | Status-reset pulse |
| oc_flag | input | N_OUT | Per-channel overcurrent comparator |
| uv_flag | input | 1 | Supply undervoltage comparator |
| ov_flag | input | 1 | Supply overvoltage comparator |
| temp_warn | input | 1 | Temperature prewarning comparator |
| temp_shdn | input | 1 | Thermal shutdown comparator |
| off_mask | output | N_OUT | Per-channel forced-off mask |
| sc_fault | output | 1 | Sticky short-circuit flag |
| psf_fault | output | 1 | Sticky power-supply-fail flag |
| therm_fault | output | 1 | Thermal shutdown latch |

## Verification
Every result of this block comes from one register stage. The prewarning trip, the supply release and the thermal set appear after the first edge that samples their input. A delayed fault appears after the edge that follows the edge sampling the last required tick. The bench drives and samples only on falling clock edges. Each tick is one clock high and one clock low. So after exactly N ticks of a timer with limit N, the latched result is already visible, and after N-1 ticks it must still be absent. The bench compares against these counts for every channel and both delay settings.

// File: rtl/fsv_pkg.sv
package fsv_pkg;

   function automatic int fsv_max(input int a, input int b);
      return (a > b) ? a : b;
   endfunction

   function automatic int fsv_cnt_width(input int limit);
      return (limit < 2) ? 1 : $clog2(limit + 1);
   endfunction

   typedef struct packed {
      logic uv_off;
      logic ov_off;
      logic therm_off;
   } fsv_global_off_t;

endpackage

// File: rtl/fsv_delay_timer.sv
module fsv_delay_timer
   import fsv_pkg::*;
#(
   parameter int LIM_LONG  = 100,
   parameter int LIM_SHORT = 12
) (
   input  logic clk,
   input  logic rst_n,
   input  logic tick,
   input  logic cond,
   input  logic restart,
   input  logic sel_long,
   output logic expired
);
   localparam int MAXL = fsv_max(LIM_LONG, LIM_SHORT);
   localparam int CW   = fsv_cnt_width(MAXL);

   logic [CW-1:0] cnt;
   logic [CW-1:0] limit;

   assign limit = sel_long ? CW'(LIM_LONG) : CW'(LIM_SHORT);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt <= '0;
      else if (!cond || restart)
         cnt <= '0;
      else if (tick && (cnt < limit))
         cnt <= cnt + 1'b1;
   end

   assign expired = cond && (cnt >= limit);

   // R10: a dropped condition restarts the count
   p_drop_clears_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !cond |=> (cnt == '0));

   // R4: restart request zeroes the count
   p_restart_r4: assert property (@(posedge clk) disable iff (!rst_n)
      restart |=> (cnt == '0));

   // R2: the count never passes the larger limit
   p_no_overflow_r2: assert property (@(posedge clk) disable iff (!rst_n)
      cnt <= CW'(MAXL));

endmodule

// File: rtl/fsv_short_channel.sv
module fsv_short_channel #(
   parameter int LIM_LONG  = 100,
   parameter int LIM_SHORT = 12
) (
   input  logic clk,
   input  logic rst_n,
   input  logic tick,
   input  logic sel_long,
   input  logic clr,
   input  logic oc,
   input  logic warn,
   output logic trip
);
   logic expired;

   fsv_delay_timer #(
      .LIM_LONG (LIM_LONG),
      .LIM_SHORT(LIM_SHORT)
   ) u_timer (
      .clk     (clk),
      .rst_n   (rst_n),
      .tick    (tick),
      .cond    (oc),
      .restart (clr),
      .sel_long(sel_long),
      .expired (expired)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         trip <= 1'b0;
      else if (clr)
         trip <= 1'b0;
      else if (expired || (oc && warn))
         trip <= 1'b1;
   end

   // R1: a trip only rises after an overcurrent was present
   p_trip_needs_oc_r1: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(trip) |-> $past(oc));

   // R3: prewarning during a short trips on the next edge
   p_prewarn_trip_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (oc && warn && !clr) |=> trip);

   // R4: status reset releases the channel
   p_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> !trip);

endmodule

// File: rtl/fsv_supply_guard.sv
module fsv_supply_guard #(
   parameter int UV_LONG  = 100,
   parameter int UV_SHORT = 12,
   parameter int OV_LONG  = 14,
   parameter int OV_SHORT = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic tick,
   input  logic sel_long,
   input  logic clr,
   input  logic uv,
   input  logic ov,
   output logic uv_off,
   output logic ov_off,
   output logic psf
);
   logic uv_exp;
   logic ov_exp;

   fsv_delay_timer #(
      .LIM_LONG (UV_LONG),
      .LIM_SHORT(UV_SHORT)
   ) u_uv_timer (
      .clk     (clk),
      .rst_n   (rst_n),
      .tick    (tick),
      .cond    (uv),
      .restart (1'b0),
      .sel_long(sel_long),
      .expired (uv_exp)
   );

   fsv_delay_timer #(
      .LIM_LONG (OV_LONG),
      .LIM_SHORT(OV_SHORT)
   ) u_ov_timer (
      .clk     (clk),
      .rst_n   (rst_n),
      .tick    (tick),
      .cond    (ov),
      .restart (1'b0),
      .sel_long(sel_long),
      .expired (ov_exp)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         uv_off <= 1'b0;
         ov_off <= 1'b0;
         psf    <= 1'b0;
      end else begin
         uv_off <= uv_exp;
         ov_off <= ov_exp;
         if (uv_exp)
            psf <= 1'b1;
         else if (clr)
            psf <= 1'b0;
      end
   end

   // R6: supply-fail only rises during undervoltage
   p_psf_needs_uv_r6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(psf) |-> $past(uv));

   // R7: undervoltage shutdown ends on the edge after recovery
   p_uv_release_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !uv |=> !uv_off);

   // R7: supply-fail is sticky without a status reset
   p_psf_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (psf && !clr) |=> psf);

   // R7: status reset with healthy supply clears the flag
   p_psf_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (clr && !uv) |=> !psf);

   // R8: overvoltage shutdown is not latched
   p_ov_release_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !ov |=> !ov_off);

endmodule

// File: rtl/fsv_thermal_latch.sv
module fsv_thermal_latch (
   input  logic clk,
   input  logic rst_n,
   input  logic shdn,
   input  logic clr,
   output logic hold
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         hold <= 1'b0;
      else if (shdn)
         hold <= 1'b1;
      else if (clr)
         hold <= 1'b0;
   end

   // R9: shutdown comparator sets the latch on the next edge
   p_therm_set_r9: assert property (@(posedge clk) disable iff (!rst_n)
      shdn |=> hold);

   // R9: latch stays unless reset arrives with the comparator clear
   p_therm_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (hold && !(clr && !shdn)) |=> hold);

endmodule

// File: rtl/fsv_fault_supervisor.sv
module fsv_fault_supervisor
   import fsv_pkg::*;
#(
   parameter int N_OUT    = 6,
   parameter int SC_LONG  = 100,
   parameter int SC_SHORT = 12,
   parameter int UV_LONG  = 100,
   parameter int UV_SHORT = 12,
   parameter int OV_LONG  = 14,
   parameter int OV_SHORT = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   input  logic             long_dly,
   input  logic             status_clr,
   input  logic [N_OUT-1:0] oc_flag,
   input  logic             uv_flag,
   input  logic             ov_flag,
   input  logic             temp_warn,
   input  logic             temp_shdn,
   output logic [N_OUT-1:0] off_mask,
   output logic             sc_fault,
   output logic             psf_fault,
   output logic             therm_fault
);
   generate
      if (N_OUT < 1)
         $error("N_OUT must be at least 1");
      if (SC_SHORT < 1 || SC_SHORT > SC_LONG)
         $error("short-circuit delays need 1 <= SC_SHORT <= SC_LONG");
      if (UV_SHORT < 1 || UV_SHORT > UV_LONG)
         $error("undervoltage delays need 1 <= UV_SHORT <= UV_LONG");
      if (OV_SHORT < 1 || OV_SHORT > OV_LONG)
         $error("overvoltage delays need 1 <= OV_SHORT <= OV_LONG");
   endgenerate

   logic [N_OUT-1:0] sc_trip;
   fsv_global_off_t  goff;

   for (genvar g = 0; g < N_OUT; g++) begin : g_chan
      fsv_short_channel #(
         .LIM_LONG (SC_LONG),
         .LIM_SHORT(SC_SHORT)
      ) u_chan (
         .clk     (clk),
         .rst_n   (rst_n),
         .tick    (tick),
         .sel_long(long_dly),
         .clr     (status_clr),
         .oc      (oc_flag[g]),
         .warn    (temp_warn),
         .trip    (sc_trip[g])
      );
   end

   fsv_supply_guard #(
      .UV_LONG (UV_LONG),
      .UV_SHORT(UV_SHORT),
      .OV_LONG (OV_LONG),
      .OV_SHORT(OV_SHORT)
   ) u_supply (
      .clk     (clk),
      .rst_n   (rst_n),
      .tick    (tick),
      .sel_long(long_dly),
      .clr     (status_clr),
      .uv      (uv_flag),
      .ov      (ov_flag),
      .uv_off  (goff.uv_off),
      .ov_off  (goff.ov_off),
      .psf     (psf_fault)
   );

   fsv_thermal_latch u_therm (
      .clk  (clk),
      .rst_n(rst_n),
      .shdn (temp_shdn),
      .clr  (status_clr),
      .hold (goff.therm_off)
   );

   assign off_mask    = sc_trip | {N_OUT{|goff}};
   assign sc_fault    = |sc_trip;
   assign therm_fault = goff.therm_off;

   // R9: a thermal shutdown forces every channel off on the next edge
   p_therm_all_off_r9: assert property (@(posedge clk) disable iff (!rst_n)
      temp_shdn |=> (&off_mask));

   // R6: supply fail comes with all channels forced off
   p_psf_all_off_r6: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(psf_fault) && uv_flag) |-> (&off_mask));

   // R4: a status reset clears the short-circuit flag
   p_sc_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
      status_clr |=> !sc_fault);

endmodule

// File: tb/fsv_fault_supervisor_bench.sv
`timescale 1ns/1ps
module fsv_fault_supervisor_bench;
   localparam int N        = 6;
   localparam int SC_L     = 7;
   localparam int SC_S     = 3;
   localparam int UV_L     = 6;
   localparam int UV_S     = 2;
   localparam int OV_L     = 5;
   localparam int OV_S     = 2;
   localparam logic [N-1:0] ALL = '1;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic tick = 1'b0;
   logic long_dly = 1'b0;
   logic status_clr = 1'b0;
   logic [N-1:0] oc_flag = '0;
   logic uv_flag = 1'b0;
   logic ov_flag = 1'b0;
   logic temp_warn = 1'b0;
   logic temp_shdn = 1'b0;
   logic [N-1:0] off_mask;
   logic sc_fault;
   logic psf_fault;
   logic therm_fault;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   always #2 clk = ~clk;

   fsv_fault_supervisor #(
      .N_OUT(N), .SC_LONG(SC_L), .SC_SHORT(SC_S),
      .UV_LONG(UV_L), .UV_SHORT(UV_S), .OV_LONG(OV_L), .OV_SHORT(OV_S)
   ) u_fsv_fault_supervisor (
      .clk(clk), .rst_n(rst_n), .tick(tick), .long_dly(long_dly),
      .status_clr(status_clr), .oc_flag(oc_flag), .uv_flag(uv_flag),
      .ov_flag(ov_flag), .temp_warn(temp_warn), .temp_shdn(temp_shdn),
      .off_mask(off_mask), .sc_fault(sc_fault), .psf_fault(psf_fault),
      .therm_fault(therm_fault)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic ticks(input int n);
      repeat (n) begin
         tick = 1'b1;
         @(negedge clk);
         tick = 1'b0;
         @(negedge clk);
      end
   endtask

   task automatic pulse_clr();
      status_clr = 1'b1;
      @(negedge clk);
      status_clr = 1'b0;
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   endtask

   initial begin
      repeat (40000) @(posedge clk);
      checks++;
      fails++;
      $display("FAIL watchdog actual=timeout expected=completion");
      finish_run();
   end

   initial begin
      idle(3);
      rst_n = 1'b1;
      idle(1);
      // R11: reset state
      chk("R11 mask", 32'(off_mask), 0);
      chk("R11 flags", {29'b0, sc_fault, psf_fault, therm_fault}, 0);

      // R1 R2 R5: sweep every channel under both delay settings
      for (int sel = 0; sel < 2; sel++) begin
         for (int i = 0; i < N; i++) begin
            int lim;
            long_dly = sel[0];
            lim = sel ? SC_L : SC_S;
            oc_flag = N'(1) << i;
            ticks(lim - 1);
            chk("R2 no trip one tick early", 32'(off_mask), 0);
            ticks(1);
            chk("R1 R5 trip mask", 32'(off_mask), 32'(1) << i);
            chk("R1 sc flag", 32'(sc_fault), 1);
            oc_flag = '0;
            pulse_clr();
            chk("R4 clear mask", 32'(off_mask), 0);
            chk("R4 clear flag", 32'(sc_fault), 0);
         end
      end

      // R10: short condition that drops before expiry restarts
      long_dly = 1'b0;
      oc_flag = 6'b000100;
      ticks(SC_S - 1);
      oc_flag = '0;
      idle(1);
      oc_flag = 6'b000100;
      ticks(SC_S - 1);
      chk("R10 restarted short timer", 32'(off_mask), 0);
      ticks(1);
      chk("R10 trip after full delay", 32'(off_mask), 32'h04);

      // R4: persistent short trips again only after a full delay
      pulse_clr();
      chk("R4 released while shorted", 32'(off_mask), 0);
      ticks(SC_S - 1);
      chk("R4 no early retrip", 32'(off_mask), 0);
      ticks(1);
      chk("R4 retrip", 32'(off_mask), 32'h04);

      // R5: second channel still counting while first one tripped
      oc_flag = 6'b010100;
      ticks(SC_S - 1);
      chk("R5 other channel unaffected", 32'(off_mask), 32'h04);
      ticks(1);
      chk("R5 second trip", 32'(off_mask), 32'h14);
      oc_flag = '0;
      pulse_clr();

      // R3: prewarning during a short trips on the next edge
      temp_warn = 1'b1;
      idle(2);
      chk("R3 warn alone", 32'(off_mask), 0);
      oc_flag = 6'b100000;
      idle(1);
      chk("R3 immediate trip", 32'(off_mask), 32'h20);
      chk("R3 sc flag", 32'(sc_fault), 1);
      oc_flag = '0;
      temp_warn = 1'b0;
      pulse_clr();

      // R6 R7: undervoltage under both settings
      for (int sel = 0; sel < 2; sel++) begin
         int lim;
         long_dly = sel[0];
         lim = sel ? UV_L : UV_S;
         uv_flag = 1'b1;
         ticks(lim - 1);
         chk("R6 uv early", {31'b0, psf_fault}, 0);
         chk("R6 uv early mask", 32'(off_mask), 0);
         ticks(1);
         chk("R6 uv all off", 32'(off_mask), 32'(ALL));
         chk("R6 psf set", 32'(psf_fault), 1);
         pulse_clr();
         chk("R7 psf kept during uv", 32'(psf_fault), 1);
         uv_flag = 1'b0;
         idle(1);
         chk("R7 outputs back", 32'(off_mask), 0);
         chk("R7 psf sticky", 32'(psf_fault), 1);
         idle(3);
         chk("R7 psf still sticky", 32'(psf_fault), 1);
         pulse_clr();
         chk("R7 psf cleared", 32'(psf_fault), 0);
      end

      // R8: overvoltage under both settings
      for (int sel = 0; sel < 2; sel++) begin
         int lim;
         long_dly = sel[0];
         lim = sel ? OV_L : OV_S;
         ov_flag = 1'b1;
         ticks(lim - 1);
         chk("R8 ov early", 32'(off_mask), 0);
         ticks(1);
         chk("R8 ov all off", 32'(off_mask), 32'(ALL));
         chk("R8 no psf", 32'(psf_fault), 0);
         ov_flag = 1'b0;
         idle(1);
         chk("R8 ov released", 32'(off_mask), 0);
      end

      // R9: thermal shutdown needs cooling and a status reset
      temp_shdn = 1'b1;
      idle(1);
      chk("R9 all off", 32'(off_mask), 32'(ALL));
      chk("R9 flag", 32'(therm_fault), 1);
      pulse_clr();
      chk("R9 reset while hot ignored", 32'(off_mask), 32'(ALL));
      temp_shdn = 1'b0;
      idle(3);
      chk("R9 cooled but held", 32'(off_mask), 32'(ALL));
      pulse_clr();
      chk("R9 released", 32'(off_mask), 0);
      chk("R9 flag cleared", 32'(therm_fault), 0);

      idle(2);
      finish_run();
   end
endmodule